// File: doc/BRIEF.md
# Multiplexed Bus Machine-Cycle Sequencer

This block turns a single bus-cycle request from an 8-bit processor core into the clock-by-clock pin activity of an external bus. The bus has a 16-bit address, and its low byte is time-shared with data. The core supplies a cycle kind, an address and write data. The sequencer then steps through T-states. It drives the high address byte and puts the low address byte on the shared lines. It pulses an address-latch strobe and sets a memory/I-O select and two status bits. It then drives the read, write or interrupt-acknowledge strobe, and it stretches the cycle while the ready input is low.

For read-type cycles, the byte on the shared lines is captured when the active phase ends. The core sees it together with a one-clock valid pulse. The block also produces four decoded strobes: memory read, memory write, I/O read and I/O write. External devices can use these directly.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset the block is idle. busy_o, ale_o, ad_oe_o and rdata_vld_o are 0. rd_no, wr_no, inta_no and the four decoded strobes are 1. io_m_o, s1_o and s0_o are 0.
- R2: A request is accepted on a clock edge where req_i is 1 and busy_o is 0. T1 follows on the next clock. kind_i encodes the cycle: 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write, 5 interrupt acknowledge. Without waits, an opcode fetch keeps busy_o high for 4 clocks and every other kind for 3 clocks.
- R3: ale_o is 1 only during T1. From T1 to the end of the cycle, addr_hi_o carries address bits 15:8. In T1, ad_o carries bits 7:0. For I/O kinds, address bits 7:0 appear on both addr_hi_o and ad_o.
- R4: io_m_o is 0 for kinds 0, 1 and 2, and 1 for kinds 3, 4 and 5.
- R5: {s1_o,s0_o} is 11 for fetch and acknowledge, 10 for reads and 01 for writes. It is set in T1 and held until the cycle ends.
- R6: The active-low strobe is driven low in T2, in every wait state and in T3. rd_no is used for kinds 0, 1 and 3, wr_no for kinds 2 and 4, and inta_no for kind 5. At most one strobe is low at a time.
- R7: ready_i is sampled at the end of T2 and at the end of each wait state. Each sample of 0 adds exactly one clock before T3.
- R8: In write cycles, ad_o carries the write data and ad_oe_o is 1 from T2 through T3. In read-type cycles, ad_oe_o is 0 after T1.
- R9: For kinds 0, 1, 3 and 5, ad_i is captured on the last clock of T3. rdata_o then holds it, and rdata_vld_o is 1 for exactly the next clock (T4 for a fetch). Write cycles give no pulse.
- R10: memr_no = rd_no OR io_m_o, ior_no = rd_no OR NOT io_m_o, memw_no = wr_no OR io_m_o, and iow_no = wr_no OR NOT io_m_o. During an acknowledge, all four stay 1.
- R11: A request with kind 6 or 7 starts no cycle, and busy_o stays 0.
- R12: req_i is ignored while busy_o is 1. The running cycle's status, strobes and length are unchanged by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Cycle request |
| kind_i | input | 3 | Cycle kind code |
| addr_i | input | 16 | Cycle address |
| wdata_i | input | 8 | Write data |
| ready_i | input | 1 | External ready, low inserts waits |
| ad_i | input | 8 | Shared address/data lines, input side |
| busy_o | output | 1 | Cycle in progress |
| addr_hi_o | output | 8 | High address byte |
| ad_o | output | 8 | Shared address/data lines, output side |
| ad_oe_o | output | 1 | Output enable for ad_o |
| ale_o | output | 1 | Address latch strobe |
| io_m_o | output | 1 | 1 = I/O space, 0 = memory |
| s1_o | output | 1 | Status bit 1 |
| s0_o | output | 1 | Status bit 0 |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| inta_no | output | 1 | Interrupt acknowledge strobe, active low |
| memr_no | output | 1 | Memory read strobe, active low |
| memw_no | output | 1 | Memory write strobe, active low |
| ior_no | output | 1 | I/O read strobe, active low |
| iow_no | output | 1 | I/O write strobe, active low |
| rdata_o | output | 8 | Captured read data |
| rdata_vld_o | output | 1 | One-clock read data valid |

## Verification
A wrong T-state shows at the pins in the same clock. ALE would appear or vanish, a strobe would fall early or late, or busy_o would last one clock too many or too few. A latched kind or address that is wrong shows in T1 as the wrong status bits or address bytes. A wrong wait-state decision shifts the strobe's rising edge by a clock. The reference model checks every pin on every clock of each cycle kind, with zero, one and several waits. This catches each of these faults within one clock of its cause.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

  localparam int unsigned KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    K_FETCH = 3'd0,
    K_MRD   = 3'd1,
    K_MWR   = 3'd2,
    K_IORD  = 3'd3,
    K_IOWR  = 3'd4,
    K_IACK  = 3'd5
  } cyc_kind_e;

  typedef enum logic [2:0] {
    TS_IDLE,
    TS_T1,
    TS_T2,
    TS_TW,
    TS_T3,
    TS_T4
  } tstate_e;

  typedef struct packed {
    logic io_m;
    logic s1;
    logic s0;
  } stat_t;

  function automatic logic kind_ok(input logic [KIND_W-1:0] k);
    return k <= K_IACK;
  endfunction

  function automatic logic is_io(input logic [KIND_W-1:0] k);
    return (k == K_IORD) || (k == K_IOWR) || (k == K_IACK);
  endfunction

  function automatic logic is_write(input logic [KIND_W-1:0] k);
    return (k == K_MWR) || (k == K_IOWR);
  endfunction

  function automatic logic is_rd(input logic [KIND_W-1:0] k);
    return (k == K_FETCH) || (k == K_MRD) || (k == K_IORD);
  endfunction

  function automatic logic takes_data(input logic [KIND_W-1:0] k);
    return is_rd(k) || (k == K_IACK);
  endfunction

  function automatic stat_t stat_of(input logic [KIND_W-1:0] k);
    stat_t s;
    s.io_m = is_io(k);
    s.s1   = !is_write(k);
    s.s0   = (k == K_FETCH) || (k == K_IACK) || is_write(k);
    return s;
  endfunction

endpackage

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
  import bus_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ready_i,
  output tstate_e           state_o,
  output logic [KIND_W-1:0] kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);

  tstate_e           state_q, state_d;
  logic [KIND_W-1:0] kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              accept;

  assign accept = (state_q == TS_IDLE) && req_i && kind_ok(kind_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TS_IDLE: if (accept) state_d = TS_T1;
      TS_T1:   state_d = TS_T2;
      TS_T2,
      TS_TW:   state_d = ready_i ? TS_T3 : TS_TW;
      TS_T3:   state_d = (kind_q == K_FETCH) ? TS_T4 : TS_IDLE;
      TS_T4:   state_d = TS_IDLE;
      default: state_d = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TS_IDLE;
      kind_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        kind_q  <= kind_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
    end
  end

  assign state_o = state_q;
  assign kind_o  = kind_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;

endmodule

// File: rtl/bus_seq_drive.sv
module bus_seq_drive
  import bus_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned HI_W  = ADDR_W - DATA_W
) (
  input  tstate_e           state_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic [HI_W-1:0]   addr_hi_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic              ale_o,
  output logic              io_m_o,
  output logic              s1_o,
  output logic              s0_o,
  output logic              rd_no,
  output logic              wr_no,
  output logic              inta_no
);

  logic  active, in_t1, strobe_ph;
  stat_t st;
  logic [HI_W-1:0]   hi_byte;
  logic [DATA_W-1:0] lo_byte;

  assign active    = (state_i != TS_IDLE);
  assign in_t1     = (state_i == TS_T1);
  assign strobe_ph = (state_i == TS_T2) || (state_i == TS_TW) || (state_i == TS_T3);
  assign st        = stat_of(kind_i);

  // I/O port number is mirrored onto the high byte
  assign lo_byte = addr_i[DATA_W-1:0];
  generate
    if (HI_W >= DATA_W) begin : g_hi_wide
      assign hi_byte = is_io(kind_i) ? HI_W'(lo_byte) : addr_i[ADDR_W-1:DATA_W];
    end else begin : g_hi_narrow
      assign hi_byte = is_io(kind_i) ? lo_byte[HI_W-1:0] : addr_i[ADDR_W-1:DATA_W];
    end
  endgenerate

  always_comb begin
    busy_o    = active;
    ale_o     = in_t1;
    addr_hi_o = active ? hi_byte : '0;
    io_m_o    = active & st.io_m;
    s1_o      = active & st.s1;
    s0_o      = active & st.s0;
    rd_no     = !(strobe_ph && is_rd(kind_i));
    wr_no     = !(strobe_ph && is_write(kind_i));
    inta_no   = !(strobe_ph && (kind_i == K_IACK));
    ad_oe_o   = in_t1 || (strobe_ph && is_write(kind_i));
    if (in_t1)      ad_o = lo_byte;
    else if (!wr_no) ad_o = wdata_i;
    else            ad_o = '0;
  end

endmodule

// File: rtl/bus_seq_strobe.sv
module bus_seq_strobe (
  input  logic rd_ni,
  input  logic wr_ni,
  input  logic io_m_i,
  output logic memr_no,
  output logic ior_no,
  output logic memw_no,
  output logic iow_no
);

  localparam int unsigned N_STB = 4;
  logic [N_STB-1:0] stb;

  // bit0 selects space (1 = I/O), bit1 selects direction (1 = write)
  for (genvar g = 0; g < N_STB; g++) begin : g_stb
    localparam bit IS_WR = (g / 2) == 1;
    localparam bit IS_IO = (g % 2) == 1;
    assign stb[g] = (IS_WR ? wr_ni : rd_ni) | (IS_IO ? ~io_m_i : io_m_i);
  end

  assign memr_no = stb[0];
  assign ior_no  = stb[1];
  assign memw_no = stb[2];
  assign iow_no  = stb[3];

endmodule

// File: rtl/bus_seq_capture.sv
module bus_seq_capture
  import bus_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tstate_e           state_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_vld_o
);

  logic take;
  assign take = (state_i == TS_T3) && takes_data(kind_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o     <= '0;
      rdata_vld_o <= 1'b0;
    end else begin
      rdata_vld_o <= take;
      if (take) rdata_o <= ad_i;
    end
  end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ready_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic              busy_o,
  output logic [HI_W-1:0]   addr_hi_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic              ale_o,
  output logic              io_m_o,
  output logic              s1_o,
  output logic              s0_o,
  output logic              rd_no,
  output logic              wr_no,
  output logic              inta_no,
  output logic              memr_no,
  output logic              memw_no,
  output logic              ior_no,
  output logic              iow_no,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_vld_o
);

  tstate_e           state;
  logic [KIND_W-1:0] kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  bus_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .kind_i  (kind_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .ready_i (ready_i),
    .state_o (state),
    .kind_o  (kind_q),
    .addr_o  (addr_q),
    .wdata_o (wdata_q)
  );

  bus_seq_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_drive (
    .state_i   (state),
    .kind_i    (kind_q),
    .addr_i    (addr_q),
    .wdata_i   (wdata_q),
    .busy_o    (busy_o),
    .addr_hi_o (addr_hi_o),
    .ad_o      (ad_o),
    .ad_oe_o   (ad_oe_o),
    .ale_o     (ale_o),
    .io_m_o    (io_m_o),
    .s1_o      (s1_o),
    .s0_o      (s0_o),
    .rd_no     (rd_no),
    .wr_no     (wr_no),
    .inta_no   (inta_no)
  );

  bus_seq_strobe i_strobe (
    .rd_ni   (rd_no),
    .wr_ni   (wr_no),
    .io_m_i  (io_m_o),
    .memr_no (memr_no),
    .ior_no  (ior_no),
    .memw_no (memw_no),
    .iow_no  (iow_no)
  );

  bus_seq_capture #(.DATA_W(DATA_W)) i_capture (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (state),
    .kind_i      (kind_q),
    .ad_i        (ad_i),
    .rdata_o     (rdata_o),
    .rdata_vld_o (rdata_vld_o)
  );

endmodule

// File: rtl/bus_cycle_seq_chk.sv
module bus_cycle_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic ale_o,
  input logic ad_oe_o,
  input logic io_m_o,
  input logic s1_o,
  input logic s0_o,
  input logic rd_no,
  input logic wr_no,
  input logic inta_no,
  input logic memr_no,
  input logic ior_no,
  input logic rdata_vld_o
);

  // R3
  ale_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);

  // R3
  ale_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> busy_o);

  // R5
  status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !ale_o) |-> $stable({io_m_o, s1_o, s0_o}));

  // R6
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({~rd_no, ~wr_no, ~inta_no}) <= 1);

  // R4
  ack_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inta_no |-> (io_m_o && s1_o && s0_o));

  // R8
  write_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> ad_oe_o);

  // R9
  vld_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_vld_o |=> !rdata_vld_o);

  // R10
  memr_space_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !memr_no |-> (!rd_no && !io_m_o && ior_no));

endmodule

bind bus_cycle_seq bus_cycle_seq_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .ale_o       (ale_o),
  .ad_oe_o     (ad_oe_o),
  .io_m_o      (io_m_o),
  .s1_o        (s1_o),
  .s0_o        (s0_o),
  .rd_no       (rd_no),
  .wr_no       (wr_no),
  .inta_no     (inta_no),
  .memr_no     (memr_no),
  .ior_no      (ior_no),
  .rdata_vld_o (rdata_vld_o)
);

// File: tb/test_bus_cycle_seq.sv
`timescale 1ns/1ps
module test_bus_cycle_seq;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [2:0] kind = '0;
  logic [15:0] addr = '0;
  logic [7:0] wdata = '0;
  logic ready = 1'b1;
  logic [7:0] ad_in = '0;
  logic busy, ale, ad_oe, io_m, s1, s0, rd_n, wr_n, inta_n;
  logic memr_n, memw_n, ior_n, iow_n, vld;
  logic [7:0] addr_hi, ad_out, rdata;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  bus_cycle_seq i_bus_cycle_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .kind_i(kind), .addr_i(addr),
    .wdata_i(wdata), .ready_i(ready), .ad_i(ad_in), .busy_o(busy),
    .addr_hi_o(addr_hi), .ad_o(ad_out), .ad_oe_o(ad_oe), .ale_o(ale),
    .io_m_o(io_m), .s1_o(s1), .s0_o(s0), .rd_no(rd_n), .wr_no(wr_n),
    .inta_no(inta_n), .memr_no(memr_n), .memw_no(memw_n), .ior_no(ior_n),
    .iow_no(iow_n), .rdata_o(rdata), .rdata_vld_o(vld)
  );

  task automatic chk(input string req_tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at %0t: actual %h expected %h", req_tag, what, $time, act, exp);
    end
  endtask

  task automatic chk_idle(input string req_tag);
    chk(req_tag, "busy", 16'(busy), 16'h0);
    chk(req_tag, "ale/oe", 16'({ale, ad_oe}), 16'h0);
    chk(req_tag, "strobes", 16'({rd_n, wr_n, inta_n, memr_n, memw_n, ior_n, iow_n}), 16'h7f);
    chk(req_tag, "status", 16'({io_m, s1, s0}), 16'h0);
  endtask

  // Behavioural model: one call per bus cycle, compares every clock
  task automatic run(input int k, input logic [15:0] a, input logic [7:0] wd,
                     input int nw, input logic [7:0] rdv, input bit spur);
    bit io   = (k >= 3);
    bit rdk  = (k == 0) || (k == 1) || (k == 3);
    bit wrk  = (k == 2) || (k == 4);
    bit ack  = (k == 5);
    logic [2:0] st;
    int nph  = 3 + nw + ((k == 0) ? 1 : 0);
    case (k)
      0: st = 3'b011; 1: st = 3'b010; 2: st = 3'b001;
      3: st = 3'b110; 4: st = 3'b101; default: st = 3'b111;
    endcase
    @(negedge clk);
    req = 1'b1; kind = 3'(k); addr = a; wdata = wd; ready = 1'b1;
    for (int p = 0; p < nph; p++) begin
      int ph;
      bit stb;
      @(negedge clk);
      if (p == 0) begin req = 1'b0; kind = 3'd7; addr = ~a; wdata = ~wd; end
      if (spur && p == 1) begin req = 1'b1; kind = 3'd4; end
      if (spur && p == 2) req = 1'b0;
      ph = (p == 0) ? 1 : (p <= 1 + nw) ? 2 : (p == 2 + nw) ? 3 : 4;
      ready = (ph == 2 && (p - 1) < nw) ? 1'b0 : 1'b1;
      ad_in = (ph == 3) ? rdv : 8'h5a;
      stb = (ph == 2) || (ph == 3);
      chk("R2", "busy", 16'(busy), 16'h1);
      chk("R3", "ale", 16'(ale), 16'(ph == 1));
      chk("R3", "addr_hi", 16'(addr_hi), 16'(io ? a[7:0] : a[15:8]));
      chk("R4", "io_m", 16'(io_m), 16'(st[2]));
      chk("R5", "s1s0", 16'({s1, s0}), 16'(st[1:0]));
      chk("R6", "rd/wr/inta", 16'({rd_n, wr_n, inta_n}),
          16'({!(stb && rdk), !(stb && wrk), !(stb && ack)}));
      chk("R10", "memr/ior/memw/iow", 16'({memr_n, ior_n, memw_n, iow_n}),
          16'({!(stb && rdk && !io), !(stb && rdk && io),
               !(stb && wrk && !io), !(stb && wrk && io)}));
      chk("R8", "ad_oe", 16'(ad_oe), 16'((ph == 1) || (stb && wrk)));
      if (ph == 1) chk("R3", "ad low address", 16'(ad_out), 16'(a[7:0]));
      if (stb && wrk) chk("R8", "ad write data", 16'(ad_out), 16'(wd));
      chk("R9", "vld", 16'(vld), 16'(ph == 4));
      if (ph == 4) chk("R9", "fetch data", 16'(rdata), 16'(rdv));
      if (ph == 3 && nw > 0) chk("R7", "T3 reached after waits", 16'(p), 16'(2 + nw));
    end
    @(negedge clk);
    ready = 1'b1;
    chk_idle("R2");
    chk("R9", "vld after T3", 16'(vld), 16'((rdk || ack) && k != 0));
    if ((rdk || ack) && k != 0) chk("R9", "rdata", 16'(rdata), 16'(rdv));
    if (spur) chk("R12", "no cycle from ignored request", 16'(busy), 16'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1;
    chk_idle("R1");
    chk("R1", "vld", 16'(vld), 16'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1");
    run(0, 16'h2000, 8'h00, 0, 8'h3e, 1'b0);
    run(1, 16'h2001, 8'h00, 0, 8'h32, 1'b0);
    run(2, 16'h8a55, 8'hc3, 0, 8'h00, 1'b0);
    run(3, 16'h0030, 8'h00, 0, 8'h77, 1'b0);
    run(4, 16'h0050, 8'h9d, 0, 8'h00, 1'b0);
    run(5, 16'h1234, 8'h00, 0, 8'hef, 1'b0);
    // R7 wait states
    run(0, 16'hfff0, 8'h00, 1, 8'ha1, 1'b0);
    run(1, 16'h4321, 8'h00, 3, 8'h5c, 1'b0);
    run(4, 16'h00f9, 8'h6b, 2, 8'h00, 1'b0);
    run(5, 16'h0000, 8'h00, 4, 8'hd7, 1'b0);
    run(2, 16'hffff, 8'hff, 1, 8'h00, 1'b0);
    // R12 request while busy
    run(1, 16'h0707, 8'h00, 0, 8'h18, 1'b1);
    run(3, 16'h00ab, 8'h00, 2, 8'h81, 1'b1);
    // R11 unsupported kinds
    for (int u = 6; u < 8; u++) begin
      @(negedge clk);
      req = 1'b1; kind = 3'(u); addr = 16'h1111;
      @(negedge clk);
      req = 1'b0;
      chk_idle("R11");
      @(negedge clk);
      chk_idle("R11");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule